// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a slave on a two-wire serial control bus. It holds a small register file and lets a bus master read and write it. The slave recognises its own 7-bit device address and then takes a one-byte register address, which loads an internal register pointer. After that, the master either sends data bytes, which are stored one after another, or issues a repeated start with the read bit set and clocks bytes out of the register file. The pointer keeps its value across a repeated start and between transactions, so a combined write-then-read transaction can read from any register.

SCL and SDA enter through a two-flop synchroniser clocked by the system clock. All start, stop and edge decisions use the synchronised copies. The slave never drives SDA high. It only asserts `sda_oe`, which the pad uses to pull the line low, and it changes that enable only after it has seen SCL fall. The surrounding logic uses a parallel port to write a register and to read any register combinationally.

A single state machine controls the bus side. Its states are:
- `ST_IDLE`: after reset or a stop.
- `ST_ADDR`: shifting in the device address.
- `ST_ADDR_ACK`: acknowledging the device address.
- `ST_REG`: shifting in the register address.
- `ST_REG_ACK`: acknowledging the register address.
- `ST_WDATA`: shifting in a write byte.
- `ST_WDATA_ACK`: acknowledging a write byte.
- `ST_RDATA`: shifting out a read byte.
- `ST_RACK`: sampling the master's acknowledge.
- `ST_WAIT`: passive until the next start or stop.

Its transitions are:
- A start or repeated start in any state goes to `ST_ADDR`.
- A stop in any state goes to `ST_IDLE`.
- On the SCL fall after the eighth bit, `ST_ADDR` goes to `ST_ADDR_ACK` on an address match and to `ST_WAIT` otherwise.
- On the next SCL fall, `ST_ADDR_ACK` goes to `ST_RDATA` for a read and to `ST_REG` for a write.
- `ST_REG` goes to `ST_REG_ACK`, which goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate for each byte written.
- `ST_RDATA` goes to `ST_RACK`.
- `ST_RACK` goes back to `ST_RDATA` on a master ACK and to `ST_WAIT` on a NACK.

Top module: `i2cs_top`

## Requirements
- R1: The slave pulls SDA low during the ninth SCL pulse of a device-address byte whose upper seven bits equal `DEV_ADDR`, where bit 0 of that byte is 0 for write and 1 for read. The ACK seen by the master is SDA low while SCL is high.
- R2: When the device address does not match, the slave leaves SDA released during the ninth pulse (NACK). Until the next start or stop, it acknowledges nothing, drives nothing and writes no register.
- R3: The slave acknowledges the register-address byte after a matched write address. The pointer is loaded with the low log2(DEPTH) bits of that byte, so address 0x13 selects register 3 when DEPTH is 16.
- R4: The slave acknowledges every fully received write byte and stores it at the pointer. The pointer then increments and wraps from DEPTH-1 to 0.
- R5: After a matched read address, the slave sends the register at the pointer, MSB first. The pointer increments after each byte. While the master ACKs (SDA low on the ninth pulse), the next register follows.
- R6: After a master NACK, the slave releases SDA and stays released until a start or a stop, so any further clocks read as all ones.
- R7: A repeated start clears the bit and byte position and restarts address recognition. It keeps the pointer, which also survives a stop.
- R8: After reset, and after any stop, SDA is released. Reset clears all registers to zero.
- R9: `sda_oe` changes only while the synchronised SCL is low.
- R10: A host write with `host_we` high stores `host_wdata` at `host_addr` on the clock edge. `host_rdata` always shows the register at `host_addr`, and data written over the bus is visible there. If both sides write the same register in the same cycle, the bus write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| host_addr | input | $clog2(DEPTH) | Register index for the parallel port |
| host_we | input | 1 | Parallel write strobe |
| host_wdata | input | 8 | Parallel write data |
| host_rdata | output | 8 | Register at host_addr |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- **Pointer wrap.** A write starts at the last register and continues into the next one. A pointer that saturates or overruns would leave register 0 unwritten.
- **Pointer kept across a repeated start.** A combined transaction reads back bytes just written. A slave that clears the pointer on a repeated start would return register 0 instead.
- **Pointer survives a stop.** A later read with no register-address phase checks this. A slave that resets the pointer on stop would read the wrong register.
- **Foreign address.** Data follows a non-matching address. A slave that ignored the mismatch would ACK those bytes or corrupt a register.
- **Clocks after a master NACK.** Extra clocks follow the NACK. A slave that kept driving would return something other than all ones.
- **Repeated start in the middle of a write.** A slave that kept its bit count would misframe the second device address.
- **Pointer truncation.** A register address above DEPTH is sent. A wrong truncation selects the wrong register.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } state_t;

endpackage

// File: rtl/i2cs_sync.sv
// Multi-stage synchroniser for the bus lines, plus a one-cycle-delayed copy
// of the synchronised value for edge detection. Lines reset to idle-high.
module i2cs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_d
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= '1;
                end else if (g == 0) begin
                    chain[g] <= din;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_d <= '1;
        end else begin
            q_d <= chain[STAGES-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
// Bus condition decoder working on synchronised SCL/SDA and their delayed copies.
module i2cs_cond (
    input  logic scl,
    input  logic sda,
    input  logic scl_d,
    input  logic sda_d,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    assign scl_rise  = scl & ~scl_d;
    assign scl_fall  = ~scl & scl_d;
    assign start_det = scl & scl_d & sda_d & ~sda;
    assign stop_det  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/i2cs_regfile.sv
// Register file with a bus-side port and a host-side port; bus write wins a clash.
module i2cs_regfile #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (host_we) mem[host_addr] <= host_wdata;
            if (bus_we)  mem[bus_addr]  <= bus_wdata;
        end
    end

    assign bus_rdata  = mem[bus_addr];
    assign host_rdata = mem[host_addr];
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         DEPTH    = 16,
    parameter int         STAGES   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe,
    input  logic [$clog2(DEPTH)-1:0] host_addr,
    input  logic                     host_we,
    input  logic [BYTE_W-1:0]        host_wdata,
    output logic [BYTE_W-1:0]        host_rdata
);
    localparam int AW = $clog2(DEPTH);

    logic              scl_s, sda_s, scl_d, sda_d;
    logic              scl_rise, scl_fall, start_det, stop_det;
    state_t            state, state_d;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sr, tx, rd_byte;
    logic [AW-1:0]     ptr;
    logic              rw, mack, bus_we, byte_done;

    i2cs_sync #(.W(2), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}),
        .q({scl_s, sda_s}), .q_d({scl_d, sda_d})
    );

    i2cs_cond u_cond (
        .scl(scl_s), .sda(sda_s), .scl_d(scl_d), .sda_d(sda_d),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_done = (cnt == 4'd8);
    assign bus_we    = scl_fall && !start_det && !stop_det
                       && (state == ST_WDATA) && byte_done;

    i2cs_regfile #(.DEPTH(DEPTH), .DW(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(ptr), .bus_wdata(sr), .bus_rdata(rd_byte),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_ADDR:      if (byte_done) state_d = (sr[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:  state_d = rw ? ST_RDATA : ST_REG;
                ST_REG:       if (byte_done) state_d = ST_REG_ACK;
                ST_REG_ACK:   state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: state_d = ST_WDATA;
                ST_RDATA:     if (byte_done) state_d = ST_RACK;
                ST_RACK:      state_d = mack ? ST_RDATA : ST_WAIT;
                default:      state_d = state;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sr     <= '0;
            tx     <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            if (scl_rise) begin
                if (state inside {ST_ADDR, ST_REG, ST_WDATA, ST_RDATA}) begin
                    sr  <= {sr[6:0], sda_s};
                    cnt <= cnt + 4'd1;
                end
                if (state == ST_RACK) mack <= !sda_s;
            end
            if (scl_fall) begin
                unique case (state)
                    ST_ADDR: if (byte_done) begin
                        rw     <= sr[0];
                        sda_oe <= (sr[7:1] == DEV_ADDR);
                    end
                    ST_REG: if (byte_done) begin
                        ptr    <= sr[AW-1:0];
                        sda_oe <= 1'b1;
                    end
                    ST_WDATA: if (byte_done) begin
                        ptr    <= ptr + 1'b1;
                        sda_oe <= 1'b1;
                    end
                    ST_REG_ACK, ST_WDATA_ACK: begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                    end
                    ST_ADDR_ACK, ST_RACK: begin
                        cnt <= '0;
                        if ((state == ST_ADDR_ACK) ? rw : mack) begin
                            tx     <= rd_byte;
                            sda_oe <= !rd_byte[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_RDATA: if (byte_done) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                    end else begin
                        tx     <= {tx[6:0], 1'b0};
                        sda_oe <= !tx[6];
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          scl_s,
    input logic          start_det,
    input state_t        state,
    input logic [AW-1:0] ptr
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R9

    AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_ADDR_ACK, ST_REG_ACK, ST_WDATA_ACK}) |-> sda_oe); // R1

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_oe); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe); // R8

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR)); // R7

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA_ACK && $past(state) == ST_WDATA)
        |-> (ptr == AW'($past(ptr) + 1'b1))); // R4
endmodule

bind i2cs_top i2cs_checker #(.AW($clog2(DEPTH))) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
    .start_det(start_det), .state(state), .ptr(ptr)
);

// File: tb/i2cs_top_bench.sv
module i2cs_top_bench;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int QC    = 5;
    localparam int HC    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_oe;
    logic          sda_bus;
    logic [AW-1:0] host_addr = '0;
    logic          host_we = 1'b0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2cs_top #(.DEV_ADDR(7'h2A), .DEPTH(DEPTH)) u_i2cs_top (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    typedef struct {
        string      tag;
        logic [7:0] v;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] obs_q[$];
    int         n_cmp = 0;
    int         n_bad = 0;

    task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor: pops expected/observed pairs as results appear
    always @(negedge clk) begin
        item_t      e;
        logic [7:0] o;
        if (exp_q.size() > 0 && obs_q.size() > 0) begin
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            check(e.tag, o, e.v);
        end
    end

    task automatic wait_c(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_c(QC);
        scl_m = 1'b1; wait_c(QC);
        sda_m = 1'b0; wait_c(QC);
        scl_m = 1'b0; wait_c(QC);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_c(QC);
        scl_m = 1'b1; wait_c(QC);
        sda_m = 1'b1; wait_c(QC);
    endtask

    task automatic put_bit(logic b);
        sda_m = b;    wait_c(QC);
        scl_m = 1'b1; wait_c(HC);
        scl_m = 1'b0; wait_c(QC);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_c(QC);
        scl_m = 1'b1; wait_c(HC / 2);
        b = sda_bus;  wait_c(HC / 2);
        scl_m = 1'b0; wait_c(QC);
    endtask

    // Driver: sends a byte, expects ACK (1) or NACK (0)
    task automatic send_byte(logic [7:0] v, logic exp_ack, string tag);
        item_t it;
        logic  b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        it.tag = tag;
        it.v   = {7'd0, exp_ack};
        exp_q.push_back(it);
        get_bit(b);
        obs_q.push_back({7'd0, ~b});
    endtask

    // Driver: reads a byte, then answers ACK (mack=1) or NACK
    task automatic recv_byte(logic [7:0] expv, logic mack, string tag);
        item_t      it;
        logic       b;
        logic [7:0] d = '0;
        it.tag = tag;
        it.v   = expv;
        exp_q.push_back(it);
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            d = {d[6:0], b};
        end
        obs_q.push_back(d);
        put_bit(!mack);
    endtask

    task automatic host_write(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_check(logic [AW-1:0] a, logic [7:0] expv, string tag);
        @(negedge clk);
        host_addr = a;
        #1;
        check(tag, host_rdata, expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait_c(4);
        rst_n = 1'b1;
        wait_c(4);

        // R8: reset state
        check("R8 reset sda_oe", {7'd0, sda_oe}, 8'h00);
        host_check(4'd0, 8'h00, "R8 reset reg0");
        host_check(4'd9, 8'h00, "R8 reset reg9");

        // R10: host writes used later by bus reads
        host_write(4'd3, 8'hA5);
        host_write(4'd4, 8'h3C);

        // R1 R3 R4: plain write of two bytes to reg 5
        bus_start();
        send_byte(8'h54, 1'b1, "R1 addr ack");
        send_byte(8'h05, 1'b1, "R3 reg ack");
        send_byte(8'h11, 1'b1, "R4 data ack");
        send_byte(8'h22, 1'b1, "R4 data ack 2");
        bus_stop();
        check("R8 released after stop", {7'd0, sda_oe}, 8'h00);
        host_check(4'd5, 8'h11, "R4 R10 reg5");
        host_check(4'd6, 8'h22, "R4 R10 reg6");

        // R4: pointer wrap from last register to 0
        bus_start();
        send_byte(8'h54, 1'b1, "R1 addr ack");
        send_byte(8'h0F, 1'b1, "R3 reg ack");
        send_byte(8'h77, 1'b1, "R4 wrap ack");
        send_byte(8'h88, 1'b1, "R4 wrap ack 2");
        bus_stop();
        host_check(4'd15, 8'h77, "R4 reg15");
        host_check(4'd0, 8'h88, "R4 wrap reg0");

        // R5 R6 R7: combined write-then-read, three bytes, then clocks after NACK
        bus_start();
        send_byte(8'h54, 1'b1, "R1 addr ack");
        send_byte(8'h03, 1'b1, "R3 reg ack");
        bus_start();
        send_byte(8'h55, 1'b1, "R7 read addr ack after rstart");
        recv_byte(8'hA5, 1'b1, "R5 R7 read reg3");
        recv_byte(8'h3C, 1'b1, "R5 read reg4");
        recv_byte(8'h11, 1'b0, "R5 read reg5");
        recv_byte(8'hFF, 1'b0, "R6 released after nack");
        bus_stop();

        // R7: pointer survives a stop (now 6)
        bus_start();
        send_byte(8'h55, 1'b1, "R1 read addr ack");
        recv_byte(8'h22, 1'b0, "R7 pointer kept reg6");
        bus_stop();

        // R2: foreign address, following bytes ignored
        bus_start();
        send_byte(8'h60, 1'b0, "R2 addr nack");
        send_byte(8'h07, 1'b0, "R2 ignored byte");
        send_byte(8'h99, 1'b0, "R2 ignored byte 2");
        bus_stop();
        host_check(4'd7, 8'h00, "R2 reg7 untouched");

        // R7: repeated start in the middle of a write
        bus_start();
        send_byte(8'h54, 1'b1, "R1 addr ack");
        send_byte(8'h08, 1'b1, "R3 reg ack");
        send_byte(8'h5A, 1'b1, "R4 data ack");
        bus_start();
        send_byte(8'h54, 1'b1, "R7 addr ack after rstart");
        send_byte(8'h09, 1'b1, "R7 reg ack");
        send_byte(8'h6B, 1'b1, "R7 data ack");
        bus_stop();
        host_check(4'd8, 8'h5A, "R7 reg8");
        host_check(4'd9, 8'h6B, "R7 reg9");

        // R3: register address truncated to pointer width (0x13 -> 3)
        bus_start();
        send_byte(8'h54, 1'b1, "R1 addr ack");
        send_byte(8'h13, 1'b1, "R3 reg ack");
        bus_start();
        send_byte(8'h55, 1'b1, "R1 read addr ack");
        recv_byte(8'hA5, 1'b0, "R3 truncated reg3");
        bus_stop();

        // R10: host write read back over the bus
        host_write(4'd10, 8'hC3);
        bus_start();
        send_byte(8'h54, 1'b1, "R1 addr ack");
        send_byte(8'h0A, 1'b1, "R3 reg ack");
        bus_start();
        send_byte(8'h55, 1'b1, "R1 read addr ack");
        recv_byte(8'hC3, 1'b0, "R10 host data on bus");
        bus_stop();
        check("R8 released at end", {7'd0, sda_oe}, 8'h00);

        wait_c(5);
        if (exp_q.size() != 0 || obs_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R5 scoreboard actual=%0d left expected=0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule